// File: doc/BRIEF.md
# Banked Memory Configuration Decoder

This block holds the 8-bit memory configuration word of a small 8-bit CPU system with two 64K RAM banks and turns it, for every CPU address, into two memory-status lines, an I/O-select line and two active-low RAM column-strobe enables. The status lines tell the downstream logic array what kind of memory lives at the current address. Their meaning depends on which 16K quarter of the address space is being accessed. The strobe enables pick the RAM bank.

The CPU loads the word through a write port at either of two register windows. One window sits in the I/O page and exists only while the word selects I/O. The other sits at the top of memory and is always present in native mode. A write to bit 0 (the I/O select) is held back until the next falling clock edge, so the I/O decision cannot change while an access is in flight. In compatibility mode the word is ignored for region decoding, and neither window responds. A RAM-share input forces bank 0 for the bottom 1K of memory.

Top module: `memcfg_decoder`

## Requirements
- R1: After reset the word is 0x00. Address 0x4000 then gives ms0=0, ms1=0, io_sel=0, cas0_n=0 and cas1_n=1.
- R2: In native mode a write to 0xFF00, or to 0xD500 while the effective bit 0 is 0, loads all 8 bits, bit 7 included. Reading either address returns the stored word.
- R3: The effective bit 0 is taken from the stored word at the first falling clock edge after the write. io_sel equals the effective bit 0, where 0 means I/O and 1 means ROM/RAM. While the effective bit 0 is 1, 0xD500 gives no hit, reads 0x00 and ignores writes.
- R4: reg_hit is 1 in native mode for 0xFF00–0xFF04 at all times, and for 0xD500–0xD50B while the effective bit 0 is 0. It is 0 for 0xD50C and 0xFF05.
- R5: For 0x4000–0x7FFF, bit 1 = 0 (ROM) gives ms0=ms1=0, and bit 1 = 1 (RAM) gives ms0=ms1=1.
- R6: For 0x8000–0xBFFF, ms0 equals bit 3 and ms1 equals bit 2.
- R7: For 0xC000–0xFFFF outside the top window, ms0 equals bit 5 and ms1 equals bit 4.
- R8: For 0x0000–0x3FFF, ms0=ms1=1 whatever the word holds.
- R9: In native mode, addresses 0xFF00–0xFF04 drive ms0, ms1, cas0_n and cas1_n all high, whatever the word holds.
- R10: Outside the top window, bit 6 = 0 asserts cas0_n only and bit 6 = 1 asserts cas1_n only. This also applies in ROM-mapped regions.
- R11: With share_sel nonzero, addresses 0x0000–0x03FF assert cas0_n only, whatever bit 6 holds. 0x0400 and above, or share_sel = 0, follow bit 6.
- R12: In compatibility mode, ms0=ms1=1, reg_hit=0, reads return 0x00 and writes leave the word unchanged. The strobe enables still follow bit 6, and the top window no longer forces them high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The word loads on the rising edge; the effective bit 0 updates on the falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset |
| compat_mode | input | 1 | 1 selects compatibility mode, 0 selects native mode |
| cpu_addr | input | 16 | CPU address |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wr_data | input | 8 | CPU write data |
| cpu_rd_data | output | 8 | Stored word when a configuration window is hit, otherwise 0x00 |
| share_sel | input | 2 | RAM-share setting; nonzero enables the shared bottom 1K |
| reg_hit | output | 1 | Address falls in a live register window |
| ms0 | output | 1 | Memory-status line 0 |
| ms1 | output | 1 | Memory-status line 1 |
| io_sel | output | 1 | Effective I/O-select bit |
| cas0_n | output | 1 | Bank 0 column-strobe enable, active low |
| cas1_n | output | 1 | Bank 1 column-strobe enable, active low |

## Verification
Address decoding is combinational. The status lines, strobe enables, reg_hit and read data are therefore sampled 1 ns after the address changes, with no clock edge in between. A write becomes visible on the rising edge that captures it, except bit 0. The bench samples io_sel once before the following falling edge, where it must still hold the old value, and once after that edge, where it must hold the new one. Every write task releases its strobe 1 ns after the capturing edge, so each probe falls in a known half-cycle.

// File: rtl/memcfg_pkg.sv
`timescale 1ns/1ps
package memcfg_pkg;
    localparam int unsigned ADDR_W  = 16;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned SHARE_W = 2;
    // Field positions in the configuration word (decoded downstream)
    localparam int unsigned IO_BIT    = 0;
    localparam int unsigned LOROM_BIT = 1;
    localparam int unsigned MID_B1    = 2;
    localparam int unsigned MID_B0    = 3;
    localparam int unsigned HI_B1     = 4;
    localparam int unsigned HI_B0     = 5;
    localparam int unsigned BANK_BIT  = 6;

    typedef enum logic [1:0] {
        QTR_LOW  = 2'b00,
        QTR_ROML = 2'b01,
        QTR_MID  = 2'b10,
        QTR_HIGH = 2'b11
    } quarter_e;

    typedef struct packed {
        logic ms0;
        logic ms1;
        logic cas0_n;
        logic cas1_n;
    } strobes_s;
endpackage

// File: rtl/memcfg_reg.sv
`timescale 1ns/1ps
module memcfg_reg #(
    parameter int unsigned DATA_W = memcfg_pkg::DATA_W,
    parameter int unsigned IO_POS = memcfg_pkg::IO_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cfg_q,
    output logic              io_eff_q
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
    } reg_s;

    reg_s st_d, st_q;
    logic io_d, io_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.word = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Prelatch: the stored I/O bit becomes effective on the falling edge
    always_comb io_d = st_q.word[IO_POS];

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) io_q <= 1'b0;
        else        io_q <= io_d;
    end

    assign cfg_q    = st_q.word;
    assign io_eff_q = io_q;

    assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q == $past(wr_data)));
    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));
    assert_prelatch_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_eff_q == cfg_q[IO_POS]);
endmodule

// File: rtl/memcfg_window.sv
`timescale 1ns/1ps
module memcfg_window #(
    parameter int unsigned ADDR_W  = memcfg_pkg::ADDR_W,
    parameter logic [ADDR_W-1:0] IO_BASE  = 16'hD500,
    parameter int unsigned       IO_CNT   = 12,
    parameter logic [ADDR_W-1:0] SYS_BASE = 16'hFF00,
    parameter int unsigned       SYS_CNT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              compat,
    input  logic              io_eff,
    output logic              cfg_hit,
    output logic              reg_hit,
    output logic              sys_hole
);
    localparam logic [ADDR_W-1:0] IO_LAST  = IO_BASE  + ADDR_W'(IO_CNT - 1);
    localparam logic [ADDR_W-1:0] SYS_LAST = SYS_BASE + ADDR_W'(SYS_CNT - 1);

    logic in_io, in_sys;

    always_comb begin
        in_io    = (addr >= IO_BASE)  && (addr <= IO_LAST);
        in_sys   = (addr >= SYS_BASE) && (addr <= SYS_LAST);
        sys_hole = !compat && in_sys;
        reg_hit  = !compat && (in_sys || (in_io && !io_eff));
        cfg_hit  = !compat && ((addr == SYS_BASE) || ((addr == IO_BASE) && !io_eff));
    end

    assert_cfg_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |-> reg_hit);
    assert_compat_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        compat |-> (!reg_hit && !cfg_hit && !sys_hole));
endmodule

// File: rtl/memcfg_map.sv
`timescale 1ns/1ps
module memcfg_map
    import memcfg_pkg::*;
#(
    parameter int unsigned ADDR_W      = memcfg_pkg::ADDR_W,
    parameter int unsigned DATA_W      = memcfg_pkg::DATA_W,
    parameter int unsigned SHARE_W     = memcfg_pkg::SHARE_W,
    parameter int unsigned SHARE_BYTES = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               compat,
    input  logic [DATA_W-1:0]  cfg,
    input  logic               sys_hole,
    input  logic [SHARE_W-1:0] share_sel,
    output strobes_s           strb
);
    localparam int unsigned SHARE_AW = $clog2(SHARE_BYTES);

    quarter_e qtr;
    logic     in_share, bank1;
    logic     unused_cfg;

    assign unused_cfg = ^{cfg[DATA_W-1:BANK_BIT+1], cfg[IO_BIT]};

    generate
        if (SHARE_AW < ADDR_W) begin : g_share
            assign in_share = (share_sel != '0) && (addr[ADDR_W-1:SHARE_AW] == '0);
        end else begin : g_share_all
            assign in_share = (share_sel != '0);
        end
    endgenerate

    always_comb begin
        qtr   = quarter_e'(addr[ADDR_W-1 -: 2]);
        bank1 = cfg[BANK_BIT] && !in_share;
        strb  = '{ms0: 1'b1, ms1: 1'b1, cas0_n: bank1, cas1_n: !bank1};
        if (!compat) begin
            unique case (qtr)
                QTR_LOW:  begin strb.ms0 = 1'b1;          strb.ms1 = 1'b1;          end
                QTR_ROML: begin strb.ms0 = cfg[LOROM_BIT]; strb.ms1 = cfg[LOROM_BIT]; end
                QTR_MID:  begin strb.ms0 = cfg[MID_B0];    strb.ms1 = cfg[MID_B1];    end
                QTR_HIGH: begin strb.ms0 = cfg[HI_B0];     strb.ms1 = cfg[HI_B1];     end
                default:  begin strb.ms0 = 1'b1;          strb.ms1 = 1'b1;          end
            endcase
            if (sys_hole) strb = '{ms0: 1'b1, ms1: 1'b1, cas0_n: 1'b1, cas1_n: 1'b1};
        end
    end

    assert_hole_all_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_hole |-> (strb.ms0 && strb.ms1 && strb.cas0_n && strb.cas1_n));
    assert_one_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_hole |-> ($countones({strb.cas0_n, strb.cas1_n}) == 1));
    assert_share_bank0_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_share && !sys_hole) |-> (!strb.cas0_n && strb.cas1_n));
    assert_compat_ms_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
        compat |-> (strb.ms0 && strb.ms1));
    assert_low_quarter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (qtr == QTR_LOW) |-> (strb.ms0 && strb.ms1));
endmodule

// File: rtl/memcfg_decoder.sv
`timescale 1ns/1ps
module memcfg_decoder
    import memcfg_pkg::*;
#(
    parameter int unsigned ADDR_W  = memcfg_pkg::ADDR_W,
    parameter int unsigned DATA_W  = memcfg_pkg::DATA_W,
    parameter int unsigned SHARE_W = memcfg_pkg::SHARE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               compat_mode,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_wr_en,
    input  logic [DATA_W-1:0]  cpu_wr_data,
    output logic [DATA_W-1:0]  cpu_rd_data,
    input  logic [SHARE_W-1:0] share_sel,
    output logic               reg_hit,
    output logic               ms0,
    output logic               ms1,
    output logic               io_sel,
    output logic               cas0_n,
    output logic               cas1_n
);
    logic [DATA_W-1:0] cfg_q;
    logic              io_eff, cfg_hit, sys_hole, wr_accept;
    strobes_s          strb;

    assign wr_accept = cpu_wr_en && cfg_hit;

    memcfg_reg #(.DATA_W(DATA_W), .IO_POS(IO_BIT)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_accept), .wr_data(cpu_wr_data),
        .cfg_q(cfg_q), .io_eff_q(io_eff)
    );

    memcfg_window #(.ADDR_W(ADDR_W)) u_win (
        .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .compat(compat_mode),
        .io_eff(io_eff), .cfg_hit(cfg_hit), .reg_hit(reg_hit), .sys_hole(sys_hole)
    );

    memcfg_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHARE_W(SHARE_W)) u_map (
        .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .compat(compat_mode),
        .cfg(cfg_q), .sys_hole(sys_hole), .share_sel(share_sel), .strb(strb)
    );

    assign cpu_rd_data = cfg_hit ? cfg_q : '0;
    assign io_sel      = io_eff;
    assign ms0         = strb.ms0;
    assign ms1         = strb.ms1;
    assign cas0_n      = strb.cas0_n;
    assign cas1_n      = strb.cas1_n;

    assert_rd_zero_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_hit |-> (cpu_rd_data == '0));
    assert_compat_no_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        compat_mode |=> $stable(cfg_q));
endmodule

// File: tb/memcfg_decoder_tb_top.sv
`timescale 1ns/1ps
module memcfg_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        compat_mode = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_wr_en = 1'b0;
    logic [7:0]  cpu_wr_data = 8'h00;
    logic [7:0]  cpu_rd_data;
    logic [1:0]  share_sel = 2'b00;
    logic        reg_hit, ms0, ms1, io_sel, cas0_n, cas1_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    memcfg_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .compat_mode(compat_mode), .cpu_addr(cpu_addr),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_rd_data(cpu_rd_data),
        .share_sel(share_sel), .reg_hit(reg_hit), .ms0(ms0), .ms1(ms1),
        .io_sel(io_sel), .cas0_n(cas0_n), .cas1_n(cas1_n)
    );

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(posedge clk); #1;
        cpu_addr = a; cpu_wr_data = d; cpu_wr_en = 1'b1;
        @(posedge clk); #1;
        cpu_wr_en = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic probe(logic [15:0] a);
        cpu_addr = a; #1;
    endtask

    task automatic t_reset();
        probe(16'h4000);
        check("R1", "ms", {6'd0, ms0, ms1}, 8'h00);
        check("R1", "io_sel", {7'd0, io_sel}, 8'h00);
        check("R1", "cas", {6'd0, cas0_n, cas1_n}, 8'h01);
        probe(16'hFF00);
        check("R1", "rd", cpu_rd_data, 8'h00);
    endtask

    task automatic t_write_read();
        wr(16'hFF00, 8'h80); settle();
        probe(16'hD500); check("R2", "rd D500", cpu_rd_data, 8'h80);
        probe(16'hFF00); check("R2", "rd FF00", cpu_rd_data, 8'h80);
        wr(16'hD500, 8'h00); settle();
        probe(16'hFF00); check("R2", "rd after D500 write", cpu_rd_data, 8'h00);
        probe(16'hD50B); check("R4", "hit D50B", {7'd0, reg_hit}, 8'h01);
        probe(16'hD50C); check("R4", "hit D50C", {7'd0, reg_hit}, 8'h00);
        probe(16'hFF04); check("R4", "hit FF04", {7'd0, reg_hit}, 8'h01);
        probe(16'hFF05); check("R4", "hit FF05", {7'd0, reg_hit}, 8'h00);
    endtask

    task automatic t_prelatch();
        wr(16'hFF00, 8'h01);
        probe(16'hD500);
        check("R3", "io_sel before fall", {7'd0, io_sel}, 8'h00);
        check("R3", "D500 hit before fall", {7'd0, reg_hit}, 8'h01);
        settle();
        check("R3", "io_sel after fall", {7'd0, io_sel}, 8'h01);
        probe(16'hD500);
        check("R3", "D500 hidden", {7'd0, reg_hit}, 8'h00);
        check("R3", "D500 rd hidden", cpu_rd_data, 8'h00);
        probe(16'hFF02); check("R4", "FF02 hit io off", {7'd0, reg_hit}, 8'h01);
        wr(16'hD500, 8'h55); settle();
        probe(16'hFF00); check("R3", "hidden write ignored", cpu_rd_data, 8'h01);
        wr(16'hFF00, 8'h00); settle();
        check("R3", "io_sel back", {7'd0, io_sel}, 8'h00);
    endtask

    task automatic t_lowrom();
        wr(16'hFF00, 8'h00); settle();
        probe(16'h4000); check("R5", "rom 4000", {6'd0, ms0, ms1}, 8'h00);
        probe(16'h7FFF); check("R5", "rom 7FFF", {6'd0, ms0, ms1}, 8'h00);
        wr(16'hFF00, 8'h02); settle();
        probe(16'h5000); check("R5", "ram 5000", {6'd0, ms0, ms1}, 8'h03);
    endtask

    task automatic t_mid();
        for (int v = 0; v < 4; v++) begin
            wr(16'hFF00, 8'(v << 2)); settle();
            probe(16'h9000);
            check("R6", "mid ms", {6'd0, ms0, ms1}, 8'(v));
        end
    endtask

    task automatic t_high();
        for (int v = 0; v < 4; v++) begin
            wr(16'hFF00, 8'(v << 4)); settle();
            probe(16'hC000);
            check("R7", "high C000", {6'd0, ms0, ms1}, 8'(v));
            probe(16'hFF05);
            check("R7", "high FF05", {6'd0, ms0, ms1}, 8'(v));
        end
    endtask

    task automatic t_lowzone();
        wr(16'hFF00, 8'h3C); settle();
        probe(16'h0000); check("R8", "low 0000", {6'd0, ms0, ms1}, 8'h03);
        probe(16'h3FFF); check("R8", "low 3FFF", {6'd0, ms0, ms1}, 8'h03);
    endtask

    task automatic t_hole();
        wr(16'hFF00, 8'h00); settle();
        for (int i = 0; i < 5; i++) begin
            probe(16'hFF00 + 16'(i));
            check("R9", "hole", {4'd0, ms0, ms1, cas0_n, cas1_n}, 8'h0F);
        end
        probe(16'hFF05);
        check("R9", "past hole", {4'd0, ms0, ms1, cas0_n, cas1_n}, 8'h01);
    endtask

    task automatic t_cas();
        wr(16'hFF00, 8'h00); settle();
        probe(16'h4000); check("R10", "bank0 in rom", {6'd0, cas0_n, cas1_n}, 8'h01);
        wr(16'hFF00, 8'h40); settle();
        probe(16'h4000); check("R10", "bank1 in rom", {6'd0, cas0_n, cas1_n}, 8'h02);
        probe(16'hE000); check("R10", "bank1 high", {6'd0, cas0_n, cas1_n}, 8'h02);
    endtask

    task automatic t_share();
        wr(16'hFF00, 8'h40); settle();
        share_sel = 2'b01;
        probe(16'h03FF); check("R11", "shared 03FF", {6'd0, cas0_n, cas1_n}, 8'h01);
        probe(16'h0400); check("R11", "unshared 0400", {6'd0, cas0_n, cas1_n}, 8'h02);
        share_sel = 2'b10;
        probe(16'h0000); check("R11", "shared code2", {6'd0, cas0_n, cas1_n}, 8'h01);
        share_sel = 2'b00;
        probe(16'h0000); check("R11", "share off", {6'd0, cas0_n, cas1_n}, 8'h02);
    endtask

    task automatic t_compat();
        wr(16'hFF00, 8'h40); settle();
        compat_mode = 1'b1;
        probe(16'h4000);
        check("R12", "compat ms", {6'd0, ms0, ms1}, 8'h03);
        check("R12", "compat cas", {6'd0, cas0_n, cas1_n}, 8'h02);
        probe(16'hFF00);
        check("R12", "compat no hit", {7'd0, reg_hit}, 8'h00);
        check("R12", "compat rd", cpu_rd_data, 8'h00);
        check("R12", "compat FF00 cas", {6'd0, cas0_n, cas1_n}, 8'h02);
        wr(16'hFF00, 8'h00); settle();
        compat_mode = 1'b0;
        probe(16'hFF00);
        check("R12", "compat write ignored", cpu_rd_data, 8'h40);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_prelatch();
        t_lowrom();
        t_mid();
        t_high();
        t_lowzone();
        t_hole();
        t_cas();
        t_share();
        t_compat();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule